// File: doc/BRIEF.md
# Two-Phase Eight-Stage Phase Token Ring

This block reproduces, cycle for cycle, the phase sequencer of a small processor that runs on two non-overlapping phase clocks. Both phase clocks arrive as enables sampled on a fast system clock. The sequencer is a ring of eight master/slave stages. Each stage has a master half and a slave half. The master half loads on the first phase enable and the slave half loads on the second. Each slave half drives the next stage, and the last slave feeds back to the first stage.

A seed input plants a single token in stage 0. After that, every master-then-slave enable pair moves the token one stage along the ring. The eight slave halves are brought out as the phase strobes, so exactly one strobe is high at a time. Every output is a register on the system clock. The strobes therefore change on a fixed, documented system-clock edge, and a bench or a neighbouring block can align to them without guessing.

Top module: `phase_ring`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, all masters and slaves clear. `phase` reads 0 after that edge, and a following master/slave enable pair leaves `phase` at 0.
- R2: When `seed` is high at a rising edge (and `rst` is low), stage 0 is loaded in both halves and every other stage is cleared. `phase` reads 8'b0000_0001 (bit 0 set) after that edge, whatever `load_m` and `load_s` are in that cycle.
- R3: When `load_m` is high at an edge, each master captures the slave output of the stage before it, and master 0 captures `phase[7]`. `phase` does not change on that edge.
- R4: When `load_s` is high at an edge, each slave takes its master's value. `phase` shows the new value right after that same edge. Without `load_s`, `seed` or `rst`, `phase` holds.
- R5: One `load_m` pulse followed by one `load_s` pulse moves a token from `phase[k]` to `phase[k+1]`.
- R6: After seeding, eight enable pairs return the token to `phase[0]`, passing through every bit once, in ascending order.
- R7: Extra `load_s` pulses without an intervening `load_m` leave `phase` unchanged. So do repeated `load_m` pulses followed by one `load_s`: they still advance the token only one stage.
- R8: `load_m` and `load_s` are never high in the same cycle. `phase` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load_m | input | 1 | First phase enable: loads the masters |
| load_s | input | 1 | Second phase enable: loads the slaves |
| seed | input | 1 | Plants the token in stage 0 |
| phase | output | STAGES | Slave outputs, one-hot phase strobes |

## Verification
- A master load never moves `phase`. The effect of a slave load, a seed or a reset is visible right after the rising edge that samples it.
- The bench drives every input on a falling edge, so the input is sampled at the next rising edge. It reads `phase` on the falling edge after that, which is one edge after the stimulus.
- For a master load, the bench reads `phase` at that same falling-edge point to confirm that nothing moved. It then confirms the captured value only through the next slave load.

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_m,
  input  logic              load_s,
  input  logic              seed,
  output logic [STAGES-1:0] phase
);
  localparam logic [STAGES-1:0] TOKEN = STAGES'(1);

  logic [STAGES-1:0] mst, slv, d;

  assign d     = {slv[STAGES-2:0], slv[STAGES-1]};
  assign phase = slv;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst <= '0;
      slv <= '0;
    end else if (seed) begin
      mst <= TOKEN;
      slv <= TOKEN;
    end else begin
      if (load_m) mst <= d;
      if (load_s) slv <= mst;
    end
  end
endmodule

// File: rtl/phase_ring_chk.sv
module phase_ring_chk #(
  parameter int STAGES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              load_m,
  input logic              load_s,
  input logic              seed,
  input logic [STAGES-1:0] phase,
  input logic [STAGES-1:0] mst
);
  p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
    !(load_m && load_s));

  p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase));

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (phase == '0));

  p_seed_token_r2: assert property (@(posedge clk) disable iff (rst)
    seed |=> (phase == STAGES'(1)));

  p_master_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (load_m && !load_s && !seed) |=> $stable(phase));

  p_slave_copy_r4: assert property (@(posedge clk) disable iff (rst)
    (load_s && !seed) |=> (phase == $past(mst)));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!load_s && !seed) |=> $stable(phase));
endmodule

bind phase_ring phase_ring_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .load_m(load_m), .load_s(load_s),
  .seed(seed), .phase(phase), .mst(mst)
);

// File: tb/phase_ring_tb.sv
module phase_ring_tb;
  logic       clk = 0;
  logic       rst = 0, load_m = 0, load_s = 0, seed = 0;
  logic [7:0] phase;
  int         n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  phase_ring #(.STAGES(8)) u_dut (
    .clk(clk), .rst(rst), .load_m(load_m), .load_s(load_s),
    .seed(seed), .phase(phase)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: phase=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_m();
    @(negedge clk) load_m = 1;
    @(negedge clk) load_m = 0;
  endtask

  task automatic pulse_s();
    @(negedge clk) load_s = 1;
    @(negedge clk) load_s = 0;
  endtask

  task automatic do_seed();
    @(negedge clk) seed = 1;
    @(negedge clk) seed = 0;
  endtask

  task automatic t_reset_r1();
    do_seed();
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    check("R1 reset", phase, 8'h00);
    pulse_m(); pulse_s();
    check("R1 masters cleared", phase, 8'h00);
  endtask

  task automatic t_seed_r2();
    do_seed();
    check("R2 seed", phase, 8'h01);
    pulse_m(); pulse_s(); pulse_m();
    @(negedge clk) begin seed = 1; load_s = 1; end
    @(negedge clk) begin seed = 0; load_s = 0; end
    check("R2 seed overrides load_s", phase, 8'h01);
  endtask

  task automatic t_master_r3();
    do_seed();
    pulse_m();
    check("R3 master load leaves phase", phase, 8'h01);
    pulse_s();
    check("R3 master captured previous stage", phase, 8'h02);
  endtask

  task automatic t_hold_r4();
    do_seed();
    pulse_m();
    repeat (5) @(negedge clk);
    check("R4 hold without load_s", phase, 8'h01);
    pulse_s();
    check("R4 slave load visible next edge", phase, 8'h02);
  endtask

  task automatic t_walk_r5_r6();
    do_seed();
    for (int k = 1; k <= 8; k++) begin
      pulse_m(); pulse_s();
      check((k == 8) ? "R6 wrap to phase 0" : "R5 one stage per pair",
            phase, 8'(1 << (k % 8)));
      check("R8 at most one bit", 8'($countones(phase)), 8'd1);
    end
  endtask

  task automatic t_repeat_r7();
    do_seed();
    pulse_m(); pulse_s();
    pulse_s(); pulse_s();
    check("R7 extra load_s no change", phase, 8'h02);
    pulse_m(); pulse_m(); pulse_m();
    check("R7 repeated load_m no change", phase, 8'h02);
    pulse_s();
    check("R7 repeated load_m advances once", phase, 8'h04);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: phase=%b expected=finished", phase);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk) rst = 1;
    @(negedge clk) rst = 0;
    check("R1 state after reset", phase, 8'h00);
    t_reset_r1();
    t_seed_r2();
    t_master_r3();
    t_hold_r4();
    t_walk_r5_r6();
    t_repeat_r7();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule